// File: doc/BRIEF.md
# Performance Counter Read Unit

This block keeps a small set of free-running event counters and serves the privileged instruction that reads one of them. It has two classes of counter: three general-purpose counters 40 bits wide and three fixed-function counters 48 bits wide. Each counter adds one on every clock cycle in which its event input is high. It wraps to zero when it passes its maximum value.

A read arrives as a request that carries a 32-bit selector word and the processor mode at issue time. The mode is the protection-enable bit, the current privilege level, the user-read-enable control bit and a lock-prefix flag. The unit checks the request first and then either returns the selected counter as a low word and a zero-extended high word or reports exactly one fault. The fault is an undefined-opcode fault or a general-protection fault with error code zero.

The request side uses a valid/ready handshake. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being emptied in that cycle. The response side is valid/ready too. A response stays on the outputs, unchanged, until `rsp_ready` is seen high, and while it is held no new request is accepted. With `rsp_ready` tied high the response is a one-cycle strobe that appears one cycle after acceptance.

Top module: `pmc_read_unit`

## Requirements
- R1: Selector bit 30 picks the class: 0 means general-purpose, 1 means fixed-function. Selector bits 29:0 are the index within that class, and each class has indices 0 to 2.
- R2: Selector bit 31 (fast-read request) has no effect on the response.
- R3: For a general-purpose counter, `rsp_lo` is counter bits 31:0 and `rsp_hi` is counter bits 39:32 in `rsp_hi[7:0]`, with `rsp_hi[31:8]` zero.
- R4: For a fixed-function counter, `rsp_lo` is counter bits 31:0 and `rsp_hi` is counter bits 47:32 in `rsp_hi[15:0]`, with `rsp_hi[31:16]` zero.
- R5: A read is permitted when `user_rd_en` is 1, or `cpl` is 0, or `prot_en` is 0. Any other read returns `rsp_gp`=1.
- R6: A permitted read whose index is 3 or more, compared over all 30 index bits with no truncation, returns `rsp_gp`=1.
- R7: A read with `lock_pfx`=1 returns `rsp_ud`=1 and `rsp_gp`=0, whatever its privilege or selector.
- R8: A faulting response has `rsp_lo` and `rsp_hi` both zero.
- R9: Each counter adds one on each cycle its event input is high, independently of the other counters.
- R10: The value returned is the counter's value on the acceptance cycle. An event in that same cycle is not included. The response appears on the cycle after acceptance.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and all response outputs hold their values.
- R12: A synchronous active-high reset clears every counter and drives `rsp_valid`, the fault flags and both data words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_gp | input | 3 | Event inputs of the general-purpose counters |
| ev_fx | input | 3 | Event inputs of the fixed-function counters |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel | input | 32 | Selector: bit 31 fast-read, bit 30 class, bits 29:0 index |
| prot_en | input | 1 | Protection enable (0 = real mode) |
| cpl | input | 2 | Current privilege level |
| user_rd_en | input | 1 | Counter reads allowed at any privilege level |
| lock_pfx | input | 1 | Lock prefix present on the instruction |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_gp | output | 1 | General-protection fault, error code 0 |
| rsp_ud | output | 1 | Undefined-opcode fault |
| rsp_lo | output | 32 | Counter bits 31:0 |
| rsp_hi | output | 32 | Upper counter bits, zero-extended |

## Verification
The bench sends a read in the same cycle as an event on the selected counter. A unit that sampled after the increment would return a value one too high. It asks for index 3 and for indices that differ from a valid one only above bit 7. A unit that truncated the index would alias them onto real counters instead of faulting. It sends a locked read that is also unprivileged and out of range, which exposes a wrong fault priority or a double fault. Stalling the response while a second request waits shows whether a unit drops, overwrites or double-accepts requests under back-pressure.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic {
    CLS_GENERAL = 1'b0,
    CLS_FIXED   = 1'b1
  } cnt_class_e;

  localparam int SEL_FAST_BIT  = 31;
  localparam int SEL_CLASS_BIT = 30;
  localparam int SEL_IDX_W     = 30;

  typedef struct packed {
    logic        gp;
    logic        ud;
    logic [31:0] lo;
    logic [31:0] hi;
  } rd_rsp_t;

endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (inc) value <= value + W'(1);
  end
endmodule

// File: rtl/pmc_access_check.sv
module pmc_access_check
  import pmc_pkg::*;
#(
  parameter int NUM_GP = 3,
  parameter int NUM_FX = 3,
  parameter int IDX_W  = 2
) (
  input  logic [31:0]      sel,
  input  logic             prot_en,
  input  logic [1:0]       cpl,
  input  logic             user_rd_en,
  input  logic             lock_pfx,
  output logic             fault_ud,
  output logic             fault_gp,
  output cnt_class_e       cls,
  output logic [IDX_W-1:0] idx
);
  logic [SEL_IDX_W-1:0] raw_idx;
  logic                 allowed;
  logic                 in_range;

  always_comb begin
    raw_idx  = sel[SEL_IDX_W-1:0];
    cls      = cnt_class_e'(sel[SEL_CLASS_BIT]);
    idx      = raw_idx[IDX_W-1:0];
    allowed  = user_rd_en || (cpl == 2'd0) || !prot_en;
    if (cls == CLS_FIXED) in_range = raw_idx < SEL_IDX_W'(NUM_FX);
    else                  in_range = raw_idx < SEL_IDX_W'(NUM_GP);
    fault_ud = lock_pfx;
    fault_gp = !lock_pfx && (!allowed || !in_range);
  end
endmodule

// File: rtl/pmc_read_unit.sv
module pmc_read_unit
  import pmc_pkg::*;
#(
  parameter int NUM_GP = 3,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 40,
  parameter int FX_W   = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_GP-1:0] ev_gp,
  input  logic [NUM_FX-1:0] ev_fx,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_sel,
  input  logic              prot_en,
  input  logic [1:0]        cpl,
  input  logic              user_rd_en,
  input  logic              lock_pfx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_gp,
  output logic              rsp_ud,
  output logic [31:0]       rsp_lo,
  output logic [31:0]       rsp_hi
);
  localparam int MAX_N = (NUM_GP > NUM_FX) ? NUM_GP : NUM_FX;
  localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

  logic [63:0] gp_val [NUM_GP];
  logic [63:0] fx_val [NUM_FX];

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic [GP_W-1:0] v;
    pmc_counter #(.W(GP_W)) u_cnt (.clk(clk), .rst(rst), .inc(ev_gp[g]), .value(v));
    assign gp_val[g] = 64'(v);
  end

  for (genvar f = 0; f < NUM_FX; f++) begin : g_fx
    logic [FX_W-1:0] v;
    pmc_counter #(.W(FX_W)) u_cnt (.clk(clk), .rst(rst), .inc(ev_fx[f]), .value(v));
    assign fx_val[f] = 64'(v);
  end

  logic             f_ud, f_gp;
  cnt_class_e       cls;
  logic [IDX_W-1:0] idx;

  pmc_access_check #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .IDX_W(IDX_W)) u_chk (
    .sel(req_sel), .prot_en(prot_en), .cpl(cpl), .user_rd_en(user_rd_en),
    .lock_pfx(lock_pfx), .fault_ud(f_ud), .fault_gp(f_gp), .cls(cls), .idx(idx)
  );

  logic [63:0] pick;
  always_comb begin
    pick = '0;
    if (cls == CLS_FIXED) begin
      for (int i = 0; i < NUM_FX; i++)
        if (idx == IDX_W'(i)) pick = fx_val[i];
    end else begin
      for (int i = 0; i < NUM_GP; i++)
        if (idx == IDX_W'(i)) pick = gp_val[i];
    end
  end

  rd_rsp_t nxt, cur;
  always_comb begin
    nxt.ud = f_ud;
    nxt.gp = f_gp;
    nxt.lo = (f_ud || f_gp) ? 32'd0 : pick[31:0];
    nxt.hi = (f_ud || f_gp) ? 32'd0 : pick[63:32];
  end

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      cur       <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      cur       <= nxt;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
      cur       <= '0;
    end
  end

  assign rsp_gp = cur.gp;
  assign rsp_ud = cur.ud;
  assign rsp_lo = cur.lo;
  assign rsp_hi = cur.hi;
endmodule

// File: rtl/pmc_read_unit_chk.sv
module pmc_read_unit_chk #(
  parameter int NUM_GP = 3,
  parameter int GP_W   = 40,
  parameter int FX_W   = 48
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_sel,
  input logic        prot_en,
  input logic [1:0]  cpl,
  input logic        user_rd_en,
  input logic        lock_pfx,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_gp,
  input logic        rsp_ud,
  input logic [31:0] rsp_lo,
  input logic [31:0] rsp_hi
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_FAULT_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_gp || rsp_ud)) |-> (rsp_lo == 32'd0 && rsp_hi == 32'd0)); // R8
  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !(rsp_gp && rsp_ud)); // R7
  AST_LOCK_UD: assert property (@(posedge clk) disable iff (rst)
    (acc && lock_pfx) |=> (rsp_valid && rsp_ud && !rsp_gp)); // R7
  AST_PRIV_GP: assert property (@(posedge clk) disable iff (rst)
    (acc && !lock_pfx && prot_en && cpl != 2'd0 && !user_rd_en) |=> (rsp_valid && rsp_gp)); // R5
  AST_RANGE_GP: assert property (@(posedge clk) disable iff (rst)
    (acc && !lock_pfx && !req_sel[30] && req_sel[29:0] >= 30'(NUM_GP)) |=> rsp_gp); // R6
  AST_GP_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_sel[30]) |=> ((rsp_hi >> (GP_W - 32)) == 32'd0)); // R3
  AST_FX_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_hi >> (FX_W - 32)) == 32'd0)); // R4
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R11
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_lo) && $stable(rsp_hi)
                                   && $stable(rsp_gp) && $stable(rsp_ud))); // R11
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid); // R10
endmodule

bind pmc_read_unit pmc_read_unit_chk #(.NUM_GP(NUM_GP), .GP_W(GP_W), .FX_W(FX_W)) u_assert (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
  .prot_en(prot_en), .cpl(cpl), .user_rd_en(user_rd_en), .lock_pfx(lock_pfx),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_gp(rsp_gp), .rsp_ud(rsp_ud),
  .rsp_lo(rsp_lo), .rsp_hi(rsp_hi)
);

// File: tb/pmc_read_unit_tb.sv
`timescale 1ns/1ps
module pmc_read_unit_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic [2:0]  ev_gp = '0, ev_fx = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_sel = '0;
  logic        prot_en = 1'b1, user_rd_en = 1'b0, lock_pfx = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_gp, rsp_ud;
  logic [31:0] rsp_lo, rsp_hi;

  pmc_read_unit u_dut (
    .clk(clk), .rst(rst), .ev_gp(ev_gp), .ev_fx(ev_fx), .req_valid(req_valid),
    .req_ready(req_ready), .req_sel(req_sel), .prot_en(prot_en), .cpl(cpl),
    .user_rd_en(user_rd_en), .lock_pfx(lock_pfx), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_gp(rsp_gp), .rsp_ud(rsp_ud), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi)
  );

  typedef struct {
    logic        gp;
    logic        ud;
    logic [31:0] lo;
    logic [31:0] hi;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  int     n_cmp = 0, n_bad = 0;
  longint m_gp[3], m_fx[3];

  // reference counts from R9/R12
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (rst) begin m_gp[i] = 0; m_fx[i] = 0; end
      else begin
        if (ev_gp[i]) m_gp[i] = (m_gp[i] + 1) & 64'hFF_FFFF_FFFF;
        if (ev_fx[i]) m_fx[i] = (m_fx[i] + 1) & 64'hFFFF_FFFF_FFFF;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) check(1'b0, "R10 unexpected response", 64'(rsp_lo), 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_gp == e.gp, {e.tag, " gp"}, 64'(rsp_gp), 64'(e.gp));
        check(rsp_ud == e.ud, {e.tag, " ud"}, 64'(rsp_ud), 64'(e.ud));
        check(rsp_lo == e.lo, {e.tag, " lo"}, 64'(rsp_lo), 64'(e.lo));
        check(rsp_hi == e.hi, {e.tag, " hi"}, 64'(rsp_hi), 64'(e.hi));
      end
    end
  end

  function automatic exp_t predict(input logic [31:0] s, input logic pe, input logic [1:0] pl,
                                   input logic ure, input logic lk, input string tag);
    exp_t   e;
    longint v;
    e.tag = tag; e.gp = 0; e.ud = 0; e.lo = 0; e.hi = 0;
    if (lk) e.ud = 1;                                   // R7
    else if (!(ure || pl == 2'd0 || !pe)) e.gp = 1;     // R5
    else if (s[29:0] >= 30'd3) e.gp = 1;                // R6
    else begin
      v = s[30] ? m_fx[s[1:0]] : m_gp[s[1:0]];          // R1
      e.lo = v[31:0];
      e.hi = v[63:32];
    end
    return e;
  endfunction

  task automatic rd(input logic [31:0] s, input logic pe, input logic [1:0] pl,
                    input logic ure, input logic lk, input string tag);
    @(negedge clk);
    req_sel = s; prot_en = pe; cpl = pl; user_rd_en = ure; lock_pfx = lk; req_valid = 1'b1;
    sb.push_back(predict(s, pe, pl, ure, lk, tag));
    @(negedge clk);
    req_valid = 1'b0; lock_pfx = 1'b0;
  endtask

  task automatic run_ev(input logic [2:0] g, input logic [2:0] f, input int n);
    @(negedge clk);
    ev_gp = g; ev_fx = f;
    repeat (n) @(negedge clk);
    ev_gp = '0; ev_fx = '0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    check(sb.size() == 0, "R10 responses outstanding", 64'(sb.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] h_lo, h_hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(rsp_valid == 1'b0, "R12 rsp_valid after reset", 64'(rsp_valid), 0);
    check(req_ready == 1'b1, "R12 req_ready after reset", 64'(req_ready), 1);
    check(rsp_lo == 0 && rsp_hi == 0, "R12 data after reset", {rsp_hi, rsp_lo}, 0);
    for (int i = 0; i < 3; i++) begin
      rd(32'(i), 1, 2'd0, 0, 0, "R12 gp count zero");
      rd(32'h4000_0000 | 32'(i), 1, 2'd0, 0, 0, "R12 fx count zero");
    end
    // R9 independent counting, R1 class select, R3/R4 layout
    run_ev(3'b101, 3'b000, 5);
    run_ev(3'b001, 3'b011, 7);
    for (int i = 0; i < 3; i++) begin
      rd(32'(i), 1, 2'd0, 0, 0, "R9 R1 R3 gp read");
      rd(32'h4000_0000 | 32'(i), 1, 2'd0, 0, 0, "R9 R1 R4 fx read");
    end
    // R10 event in the read cycle excluded
    @(negedge clk); ev_gp = 3'b111; ev_fx = 3'b111;
    rd(32'd1, 1, 2'd0, 0, 0, "R10 same-cycle gp");
    rd(32'h4000_0002, 1, 2'd0, 0, 0, "R10 same-cycle fx");
    rd(32'd0, 1, 2'd0, 0, 0, "R10 back-to-back");
    @(negedge clk); ev_gp = '0; ev_fx = '0;
    // R2 fast bit ignored
    rd(32'h8000_0001, 1, 2'd0, 0, 0, "R2 fast gp");
    rd(32'hC000_0002, 1, 2'd0, 0, 0, "R2 fast fx");
    // R5 privilege rules
    rd(32'd0, 1, 2'd3, 0, 0, "R5 user denied");
    rd(32'd0, 1, 2'd2, 0, 0, "R5 cpl2 denied");
    rd(32'd2, 1, 2'd3, 1, 0, "R5 user allowed by enable");
    rd(32'h4000_0001, 0, 2'd3, 0, 0, "R5 real mode allowed");
    // R6 index range over all bits, R8 zero data
    rd(32'd3, 1, 2'd0, 0, 0, "R6 R8 gp index 3");
    rd(32'h4000_0005, 1, 2'd0, 0, 0, "R6 fx index 5");
    rd(32'h0000_0100, 1, 2'd0, 0, 0, "R6 alias bit8");
    rd(32'h6000_0001, 1, 2'd0, 0, 0, "R6 alias bit29");
    // R7 lock wins
    rd(32'h2000_0007, 1, 2'd3, 0, 1, "R7 lock over gp faults");
    rd(32'd0, 1, 2'd0, 0, 1, "R7 lock privileged valid sel");
    drain();
    // R11 back-pressure
    run_ev(3'b010, 3'b000, 4);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_sel = 32'd1; prot_en = 1; cpl = 2'd0; user_rd_en = 0; req_valid = 1'b1;
    sb.push_back(predict(32'd1, 1, 2'd0, 0, 0, "R11 stalled response"));
    @(negedge clk);
    req_sel = 32'h4000_0000;
    check(rsp_valid == 1'b1, "R11 response present", 64'(rsp_valid), 1);
    check(req_ready == 1'b0, "R11 ready low while stalled", 64'(req_ready), 0);
    h_lo = rsp_lo; h_hi = rsp_hi;
    ev_gp = 3'b010;
    @(negedge clk);
    check(rsp_lo == h_lo && rsp_hi == h_hi, "R11 data held", 64'(rsp_lo), 64'(h_lo));
    check(req_ready == 1'b0, "R11 ready still low", 64'(req_ready), 0);
    req_valid = 1'b0; ev_gp = '0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 no second response", 64'(rsp_valid), 0);
    // R12 reset mid-run clears counters
    run_ev(3'b111, 3'b111, 3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(32'd2, 1, 2'd0, 0, 0, "R12 gp cleared");
    rd(32'h4000_0001, 1, 2'd0, 0, 0, "R12 fx cleared");
    drain();
    finish_run();
  end
endmodule